// File: doc/BRIEF.md
# EDO DRAM Access Sequencer

This block sits between a host and an asynchronous 4M x 4 extended-data-out DRAM. The host hands it a 22-bit word address, a read or write flag, a 4-bit write value and a flag that asks to keep the row open. The sequencer places the upper eleven address bits on an 11-bit multiplexed bus as the row, then places the lower eleven bits on the same bus as the column. It drives the active-low row strobe, column strobe, write enable and output enable, and returns each read value with a one-cycle valid pulse.

Every DRAM interval is derived from nanosecond parameters and a clock-period parameter. Each nanosecond value is rounded up to whole cycles and enforced by a down-counter. Read data is captured after the column strobe has returned high, which relies on the extended-data-out hold. When the keep-open flag is set, the row stays active. A later request to the same row then needs only a column cycle. A request to another row, or an open page that is nearing the maximum row-strobe low time, causes a precharge first.

Top module: `edo_seq_top`

## Requirements
- R1: While reset is held, `rasN`, `casN`, `weN` and `oeN` are 1, `dqOe` and `rdValid` are 0, and `reqReady` is 1.
- R2: The row driven on `dAddr` when `rasN` falls equals `reqAddr[21:11]`. The column on `dAddr` when `casN` falls equals `reqAddr[10:0]`.
- R3: `casN` falls only while `rasN` is low. The first `casN` fall after a `rasN` fall comes between 15 ns and 35 ns after it.
- R4: Each `casN` low pulse lasts at least 8 ns. Each `casN` high gap inside a row lasts at least 8 ns. Successive `casN` falls within one row are at least 25 ns apart.
- R5: Each `rasN` low pulse lasts at least 50 ns. Each `rasN` high time lasts at least 30 ns. Successive `rasN` falls are at least 80 ns apart.
- R6: A write (`reqWrite`=1) has `weN`=0 and `dqOe`=1 with the write value on `dqOut` in the cycle that `casN` falls, and keeps them until `casN` rises. `oeN` stays 1 throughout the write. `dqOe`=1 never coincides with `oeN`=0.
- R7: A read (`reqWrite`=0) returns the stored value on `rdData` with a single-cycle `rdValid`. The capture takes place with `casN` already high, at least 50 ns after the row strobe fell.
- R8: A request made with `reqBurst`=1 leaves `rasN` low afterwards. A following request to the same row is served with no new `rasN` fall.
- R9: While a row is open, a request to a different row is held off (`reqReady`=0) until a precharge and a new `rasN` fall have taken place.
- R10: An open row is closed without any request, so that `rasN` is never low for longer than 10 us.
- R11: A request is taken on a clock edge with `reqValid`=1 and `reqReady`=1. `reqReady` is 0 while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Request accepted this edge when valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBurst | input | 1 | Keep the row open after this access |
| reqAddr | input | 22 | Word address, row in the upper 11 bits |
| reqWdata | input | 4 | Write value |
| rdValid | output | 1 | One-cycle read-data strobe |
| rdData | output | 4 | Captured read value |
| dAddr | output | 11 | Multiplexed DRAM address bus |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| oeN | output | 1 | Output enable, active low |
| dqOut | output | 4 | Data driven toward the DRAM |
| dqOe | output | 1 | Controller drives `dqOut` when 1 |
| dqIn | input | 4 | Data returned by the DRAM |

## Verification
At the default 20 ns clock, `rasN` falls on the edge that accepts a request from idle. `casN` falls one cycle later and rises one cycle after that. `rdValid` rises three edges after acceptance, or two edges after acceptance for a same-row request. Precharge then holds `rasN` high for two cycles. Rather than hard-coding these counts, the bench samples every pin at the falling clock edge. It timestamps each strobe transition in cycles, converts the gaps to nanoseconds, and compares them with the limits in the requirements. Read results are awaited by polling `rdValid` with a bound and then compared with a behavioural memory that latches the row and column at the strobe edges.

// File: rtl/edo_seq_pkg.sv
`timescale 1ns/1ps
package edo_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_CASLO,
    ST_CASHI,
    ST_OPEN,
    ST_PRE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture address and write value
    logic selCol;   // column on the address bus
    logic drvData;  // drive write value toward memory
    logic capture;  // latch read data
  } seqStrobe_t;

  function automatic int nsToCyc(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_seq_ctrl.sv
`timescale 1ns/1ps
module edo_seq_ctrl
  import edo_seq_pkg::*;
#(
  parameter int CLK_NS      = 20,
  parameter int RCD_MIN_NS  = 15,
  parameter int RAD_NS      = 12,
  parameter int RAS_MIN_NS  = 50,
  parameter int RAS_MAX_NS  = 10000,
  parameter int RP_NS       = 30,
  parameter int RC_NS       = 80,
  parameter int CAS_NS      = 8,
  parameter int CP_NS       = 8,
  parameter int PC_NS       = 25,
  parameter int AA_NS       = 25,
  parameter int RAC_NS      = 50,
  parameter int WCH_NS      = 10,
  parameter int DH_NS       = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       reqBurst,
  input  logic       rowHit,
  output logic       reqReady,
  output seqStrobe_t strobe,
  output logic       rasN,
  output logic       casN,
  output logic       weN,
  output logic       oeN
);

  localparam int ROW_CYC   = maxInt(nsToCyc(RCD_MIN_NS, CLK_NS), nsToCyc(RAD_NS, CLK_NS));
  localparam int CASLO_CYC = maxInt(nsToCyc(CAS_NS, CLK_NS),
                             maxInt(nsToCyc(WCH_NS, CLK_NS), nsToCyc(DH_NS, CLK_NS)));
  localparam int CASHI_CYC = maxInt(nsToCyc(CP_NS, CLK_NS),
                             maxInt(nsToCyc(PC_NS, CLK_NS) - CASLO_CYC,
                             maxInt(nsToCyc(AA_NS, CLK_NS) - CASLO_CYC,
                             maxInt(nsToCyc(RAC_NS, CLK_NS) - ROW_CYC - CASLO_CYC,
                                    nsToCyc(RAS_MIN_NS, CLK_NS) - ROW_CYC - CASLO_CYC))));
  localparam int PRE_CYC   = maxInt(nsToCyc(RP_NS, CLK_NS),
                                    nsToCyc(RC_NS, CLK_NS) - ROW_CYC - CASLO_CYC - CASHI_CYC);
  localparam int RAS_MAX_CYC = RAS_MAX_NS / CLK_NS;
  localparam int CLOSE_AT    = RAS_MAX_CYC - CASLO_CYC - CASHI_CYC - 2;
  localparam int CNT_W       = $clog2(RAS_MAX_CYC + 2);

  seqState_t        state, nxt;
  logic [CNT_W-1:0] cnt, cntVal, rasAge;
  logic             cntLoad, isWrite, keepOpen, closing, accept;

  function automatic logic rasLow(input seqState_t s);
    return (s == ST_ROW) || (s == ST_CASLO) || (s == ST_CASHI) || (s == ST_OPEN);
  endfunction

  assign closing  = (rasAge >= CNT_W'(CLOSE_AT));
  assign reqReady = (state == ST_IDLE) || (state == ST_OPEN && rowHit && !closing);
  assign accept   = reqValid && reqReady;

  always_comb begin
    nxt     = state;
    cntLoad = 1'b0;
    cntVal  = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        nxt = ST_ROW;   cntLoad = 1'b1; cntVal = CNT_W'(ROW_CYC - 1);
      end
      ST_ROW: if (cnt == '0) begin
        nxt = ST_CASLO; cntLoad = 1'b1; cntVal = CNT_W'(CASLO_CYC - 1);
      end
      ST_CASLO: if (cnt == '0) begin
        nxt = ST_CASHI; cntLoad = 1'b1; cntVal = CNT_W'(CASHI_CYC - 1);
      end
      ST_CASHI: if (cnt == '0) begin
        if (keepOpen) nxt = ST_OPEN;
        else begin nxt = ST_PRE; cntLoad = 1'b1; cntVal = CNT_W'(PRE_CYC - 1); end
      end
      ST_OPEN: begin
        if (accept) begin
          nxt = ST_CASLO; cntLoad = 1'b1; cntVal = CNT_W'(CASLO_CYC - 1);
        end else if (closing || reqValid) begin
          nxt = ST_PRE;   cntLoad = 1'b1; cntVal = CNT_W'(PRE_CYC - 1);
        end
      end
      ST_PRE: if (cnt == '0) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      isWrite  <= 1'b0;
      keepOpen <= 1'b0;
      rasAge   <= '0;
    end else begin
      state <= nxt;
      if (cntLoad)          cnt <= cntVal;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
      if (accept) begin
        isWrite  <= reqWrite;
        keepOpen <= reqBurst;
      end
      if (!rasLow(nxt))       rasAge <= '0;
      else if (rasLow(state)) rasAge <= rasAge + 1'b1;
      else                    rasAge <= CNT_W'(1);
    end
  end

  assign rasN = !rasLow(state);
  assign casN = (state != ST_CASLO);
  assign weN  = !(isWrite && (state == ST_ROW || state == ST_CASLO));
  assign oeN  = !(!isWrite && (state == ST_CASLO || state == ST_CASHI));

  assign strobe.load    = accept;
  assign strobe.selCol  = (state == ST_CASLO) || (state == ST_CASHI) || (state == ST_OPEN);
  assign strobe.drvData = isWrite && (state == ST_ROW || state == ST_CASLO);
  assign strobe.capture = (state == ST_CASHI) && (cnt == '0) && !isWrite;

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rstN) !casN |-> !rasN); // R3
  AST_RAS_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> (rasAge <= CNT_W'(RAS_MAX_CYC))); // R10
  AST_WE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!casN && !$past(casN)) |-> $stable(weN)); // R6
  AST_OE_NOT_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN) !oeN |-> weN); // R6
  AST_READY_CAS_HIGH: assert property (@(posedge clk) disable iff (!rstN) reqReady |-> casN); // R11

endmodule

// File: rtl/edo_seq_dpath.sv
`timescale 1ns/1ps
module edo_seq_dpath
  import edo_seq_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 11,
  parameter int DQ_W  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strobe,
  input  logic [ROW_W+COL_W-1:0]   reqAddr,
  input  logic [DQ_W-1:0]          reqWdata,
  output logic                     rowHit,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dAddr,
  output logic [DQ_W-1:0]          dqOut,
  output logic                     dqOe,
  input  logic [DQ_W-1:0]          dqIn,
  output logic                     rdValid,
  output logic [DQ_W-1:0]          rdData
);

  localparam int BUS_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [ROW_W-1:0] rowReg;
  logic [COL_W-1:0] colReg;
  logic [DQ_W-1:0]  wdReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg  <= '0;
      colReg  <= '0;
      wdReg   <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      if (strobe.load) begin
        rowReg <= reqAddr[ROW_W+COL_W-1:COL_W];
        colReg <= reqAddr[COL_W-1:0];
        wdReg  <= reqWdata;
      end
      rdValid <= strobe.capture;
      if (strobe.capture) rdData <= dqIn;
    end
  end

  assign rowHit = (reqAddr[ROW_W+COL_W-1:COL_W] == rowReg);
  assign dAddr  = strobe.selCol ? BUS_W'(colReg) : BUS_W'(rowReg);
  assign dqOut  = wdReg;
  assign dqOe   = strobe.drvData;

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN) rdValid |=> !rdValid); // R7

endmodule

// File: rtl/edo_seq_top.sv
`timescale 1ns/1ps
module edo_seq_top
  import edo_seq_pkg::*;
#(
  parameter int CLK_NS     = 20,
  parameter int RAS_MAX_NS = 10000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic        reqBurst,
  input  logic [21:0] reqAddr,
  input  logic [3:0]  reqWdata,
  output logic        rdValid,
  output logic [3:0]  rdData,
  output logic [10:0] dAddr,
  output logic        rasN,
  output logic        casN,
  output logic        weN,
  output logic        oeN,
  output logic [3:0]  dqOut,
  output logic        dqOe,
  input  logic [3:0]  dqIn
);

  seqStrobe_t strobe;
  logic       rowHit;

  edo_seq_ctrl #(.CLK_NS(CLK_NS), .RAS_MAX_NS(RAS_MAX_NS)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBurst(reqBurst), .rowHit(rowHit), .reqReady(reqReady), .strobe(strobe),
    .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN)
  );

  edo_seq_dpath #(.ROW_W(11), .COL_W(11), .DQ_W(4)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rowHit(rowHit), .dAddr(dAddr), .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn),
    .rdValid(rdValid), .rdData(rdData)
  );

  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rstN) dqOe |-> oeN); // R6
  AST_RDVALID_EDO: assert property (@(posedge clk) disable iff (!rstN) rdValid |-> casN); // R7

endmodule

// File: tb/edo_seq_top_test.sv
`timescale 1ns/1ps
module edo_seq_top_test;

  localparam int T_NS = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqBurst = 1'b0;
  logic [21:0] reqAddr = '0;
  logic [3:0]  reqWdata = '0;
  logic reqReady, rdValid, rasN, casN, weN, oeN, dqOe;
  logic [3:0] rdData, dqOut, dqIn;
  logic [10:0] dAddr;

  always #10 clk = ~clk;

  edo_seq_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBurst(reqBurst), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .dAddr(dAddr), .rasN(rasN), .casN(casN),
    .weN(weN), .oeN(oeN), .dqOut(dqOut), .dqOe(dqOe), .dqIn(dqIn)
  );

  // ---------------- behavioural memory and timing monitor ----------------
  logic [3:0]  mem [256];
  logic [10:0] mdlRow = '0, mdlCol = '0;
  logic        mdlOn = 1'b0;
  logic        prevRas = 1'b1, prevCas = 1'b1, prevWe = 1'b1, prevDqOe = 1'b0;
  logic        firstCas = 1'b0, wrAtFall = 1'b0;
  int cyc = 0, rasFallT = -1000, rasRiseT = -1000, casFallT = -1000, casRiseT = -1000;
  int rasFalls = 0, maxRasLoNs = 0;
  int vRcd = 0, vCasLo = 0, vCasHi = 0, vPc = 0, vRasLo = 0, vRp = 0, vRc = 0, vWr = 0, vRd = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 4'h0;

  assign dqIn = (mdlOn && !oeN) ? mem[{mdlRow[3:0], mdlCol[3:0]}] : 4'h0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (prevRas && !rasN) begin
        if ((cyc - rasRiseT) * T_NS < 30) vRp <= vRp + 1;         // R5
        if ((cyc - rasFallT) * T_NS < 80) vRc <= vRc + 1;         // R5
        rasFallT <= cyc; rasFalls <= rasFalls + 1; firstCas <= 1'b1;
        mdlRow <= dAddr;
      end
      if (!prevRas && rasN) begin
        if ((cyc - rasFallT) * T_NS < 50) vRasLo <= vRasLo + 1;   // R5
        if ((cyc - rasFallT) * T_NS > maxRasLoNs) maxRasLoNs <= (cyc - rasFallT) * T_NS;
        rasRiseT <= cyc;
      end
      if (prevCas && !casN) begin
        if (rasN) vRcd <= vRcd + 1;                               // R3
        if (firstCas && (((cyc - rasFallT) * T_NS < 15) || ((cyc - rasFallT) * T_NS > 35)))
          vRcd <= vRcd + 1;                                       // R3
        if (!firstCas && (cyc - casFallT) * T_NS < 25) vPc <= vPc + 1;   // R4
        if (!firstCas && (cyc - casRiseT) * T_NS < 8)  vCasHi <= vCasHi + 1; // R4
        firstCas <= 1'b0; casFallT <= cyc; mdlCol <= dAddr;
        wrAtFall <= !weN;
        if (!weN) begin
          if (!dqOe || !oeN) vWr <= vWr + 1;                      // R6
          mem[{mdlRow[3:0], dAddr[3:0]}] <= dqOut;
          mdlOn <= 1'b0;
        end else mdlOn <= 1'b1;
      end
      if (!prevCas && casN) begin
        if ((cyc - casFallT) * T_NS < 8) vCasLo <= vCasLo + 1;    // R4
        if (wrAtFall && (prevWe || !prevDqOe)) vWr <= vWr + 1;    // R6
        casRiseT <= cyc;
      end
      if (rasN && casN) mdlOn <= 1'b0;
      if (dqOe && !oeN) vWr <= vWr + 1;                           // R6
      if (rdValid && (!casN || (cyc - rasFallT) * T_NS < 50)) vRd <= vRd + 1; // R7
    end
    prevRas <= rasN; prevCas <= casN; prevWe <= weN; prevDqOe <= dqOe;
  end

  // ---------------- checking ----------------
  int nChecks = 0, nFail = 0;
  logic done = 1'b0;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic br, input logic [21:0] a, input logic [3:0] d);
    logic acc;
    reqValid = 1'b1; reqWrite = wr; reqBurst = br; reqAddr = a; reqWdata = d;
    for (int k = 0; k < 1000; k++) begin
      #1;
      acc = reqReady;
      @(negedge clk);
      if (acc) break;
    end
    reqValid = 1'b0;
  endtask

  task automatic waitRead(output logic got);
    got = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (rdValid) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // {write, burst, row, column, data}
  localparam logic [27:0] VEC [8] = '{
    {1'b1, 1'b1, 11'h405, 11'h603, 4'hA},
    {1'b1, 1'b1, 11'h405, 11'h004, 4'h5},
    {1'b0, 1'b1, 11'h405, 11'h603, 4'hA},
    {1'b0, 1'b0, 11'h405, 11'h004, 4'h5},
    {1'b1, 1'b0, 11'h7F9, 11'h3C1, 4'hC},
    {1'b1, 1'b1, 11'h002, 11'h7F7, 4'h3},
    {1'b0, 1'b0, 11'h7F9, 11'h3C1, 4'hC},
    {1'b0, 1'b0, 11'h002, 11'h7F7, 4'h3}
  };

  initial begin
    logic got;
    int   fallsBefore;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rasN == 1'b1, "R1 rasN", int'(rasN), 1);
    check(casN == 1'b1, "R1 casN", int'(casN), 1);
    check(weN == 1'b1,  "R1 weN",  int'(weN), 1);
    check(oeN == 1'b1,  "R1 oeN",  int'(oeN), 1);
    check(dqOe == 1'b0, "R1 dqOe", int'(dqOe), 0);
    check(rdValid == 1'b0, "R1 rdValid", int'(rdValid), 0);
    check(reqReady == 1'b1, "R1 reqReady", int'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);

    // vector table
    for (int i = 0; i < 8; i++) begin
      issue(VEC[i][27], VEC[i][26], VEC[i][25:4], VEC[i][3:0]);
      if (i == 0) check(reqReady == 1'b0, "R11 busy after accept", int'(reqReady), 0);
      if (!VEC[i][27]) begin
        waitRead(got);
        check(got && rdData == VEC[i][3:0], "R7 read data", int'(rdData), int'(VEC[i][3:0]));
      end else repeat (3) @(negedge clk);
      check(mdlRow == VEC[i][25:15], "R2 row", int'(mdlRow), int'(VEC[i][25:15]));
      check(mdlCol == VEC[i][14:4],  "R2 column", int'(mdlCol), int'(VEC[i][14:4]));
    end
    repeat (6) @(negedge clk);
    // R8 page hits add no RAS fall; R9 row miss adds one after precharge
    check(rasFalls == 5, "R8 R9 row strobe falls", rasFalls, 5);

    // R10: open row closes by itself
    issue(1'b1, 1'b1, {11'h111, 11'h00A}, 4'h6);
    repeat (700) @(negedge clk);
    check(rasN == 1'b1, "R10 row closed", int'(rasN), 1);
    check(maxRasLoNs <= 10000, "R10 max row low ns", maxRasLoNs, 10000);
    check(maxRasLoNs >= 9000, "R8 R10 row held open ns", maxRasLoNs, 9000);
    fallsBefore = rasFalls;
    issue(1'b0, 1'b0, {11'h111, 11'h00A}, 4'h0);
    waitRead(got);
    check(got && rdData == 4'h6, "R6 write before close kept", int'(rdData), 6);
    check(rasFalls == fallsBefore + 1, "R9 new row strobe after close", rasFalls, fallsBefore + 1);
    repeat (6) @(negedge clk);

    // timing limits over the whole run
    check(vRcd == 0,   "R3 row-to-column delay", vRcd, 0);
    check(vCasLo == 0, "R4 column low width", vCasLo, 0);
    check(vCasHi == 0, "R4 column precharge", vCasHi, 0);
    check(vPc == 0,    "R4 page cycle", vPc, 0);
    check(vRasLo == 0, "R5 row low width", vRasLo, 0);
    check(vRp == 0,    "R5 row precharge", vRp, 0);
    check(vRc == 0,    "R5 row cycle", vRc, 0);
    check(vWr == 0,    "R6 write strobes", vWr, 0);
    check(vRd == 0,    "R7 read capture timing", vRd, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule